// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends one SD/MMC command on the CMD line and collects the card's reply. Software first loads a 32-bit argument register. It then writes a command register that holds the 6-bit command index and the flag bits. The engine builds a 48-bit frame, appends a CRC7, and shifts the frame out most significant bit first, one bit per clock. If the command expects no reply, the engine reports that the frame has gone out. Otherwise it listens on CMD for a 48-bit or 136-bit response, checks its CRC7 and end bit, and stores it in four 32-bit response registers.

Every result is reported through a sticky status bit. A status bit stays set until software writes a one to the matching bit of a separate clear register. Registers sit on a simple single-cycle write port and a combinational read port. Addresses: 0 argument (read/write), 1 command (read/write), 2 status (read), 3 clear (write), 4 to 7 response words 0 to 3.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the status register and all four response words read zero, the engine is idle (command register bit 9 reads 0), cmd_oe_o is 0 and cmd_o is 1.
- R2: A write to address 1 with bit 9 set starts a command. Command register fields: bits 5:0 index, bit 6 response expected, bit 7 long response, bit 8 app-command mark, bit 9 enable. The frame is {0, 1, index, argument, CRC7, 1}. CRC7 uses polynomial x^7+x^3+1 over the first 40 bits. Frame bit k is driven on cmd_o, with cmd_oe_o high, in the (k+2)-th cycle after the write edge, for 48 cycles in all.
- R3: With bit 6 clear, status bit 3 (sent) sets at the edge that ends the end-bit cycle. No other status bit changes.
- R4: With bit 6 set, the response start bit is accepted if cmd_i is low at any of the 64 rising edges starting with the edge that ends the end-bit cycle. Otherwise status bit 2 (timeout) sets at the 64th of those edges.
- R5: A 48-bit response is checked with CRC7 over its first 40 bits, compared with the next 7 bits, and must end with a 1. A pass sets status bit 0 (CRC good) and a failure sets bit 1 (CRC error). Either way, response bits 39:8 go to word 0 and words 1 to 3 keep their values.
- R6: With bit 7 set, a 136-bit response is received. CRC7 runs over frame positions 8 to 127 (counting from the start bit as 0) and is compared with positions 128 to 134. Words 3 down to 0 receive frame bits 127:0, with word 3 most significant.
- R7: Every command that expects a response ends in exactly one of status bits 0, 1 or 2.
- R8: Status bits are sticky. Writing a one to a bit of address 3 clears that bit. If a bit is set and cleared at the same edge, the set wins.
- R9: Command register bit 9 reads 1 while a command is in progress. Writes to addresses 0 and 1 during that time are ignored and start nothing.
- R10: A command-register write with bit 9 clear stores the fields and starts nothing. The app-command bit reads back as written and has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one CMD bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Write address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | 32 | Read data (combinational) |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input value |

## Verification
A status bit can be set by the engine at the very edge where software writes the clear register. The bench provokes this for the sent bit by putting the clear write on the edge that ends the end-bit cycle. It provokes it for the CRC-good bit by asserting the clear write together with the response end bit. The result is judged by reading status afterwards: the new event bit must survive, and a stale bit cleared in the same write must be gone.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int unsigned CMD_FRAME_LEN = 48;
  localparam int unsigned CRC_SPAN_CMD  = 40;
  localparam int unsigned SHORT_LEN     = 48;
  localparam int unsigned LONG_LEN      = 136;
  localparam int unsigned RSP_BITS      = 128;

  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;

  localparam int unsigned F_NEED = 6;
  localparam int unsigned F_LONG = 7;
  localparam int unsigned F_APP  = 8;
  localparam int unsigned F_EN   = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX,
    ST_WAIT,
    ST_RX
  } link_state_e;

  // bit order equals status register layout
  typedef struct packed {
    logic sent;
    logic tmo;
    logic fail;
    logic ok;
  } evt_t;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic       shf_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;
  logic       fb;

  assign fb = bit_i ^ crc_q[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= {crc_q[5:0], 1'b0} ^ ({7{fb}} & 7'h09);
    else if (shf_i) crc_q <= {crc_q[5:0], 1'b0};
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sdcmd_link.sv
module sdcmd_link
  import sdcmd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [5:0]          idx_i,
  input  logic [31:0]         arg_i,
  input  logic                need_i,
  input  logic                long_i,
  input  logic                cmd_i,
  output logic                cmd_o,
  output logic                cmd_oe_o,
  output logic                busy_o,
  output evt_t                evt_o,
  output logic                rsp_we_o,
  output logic                rsp_long_o,
  output logic [RSP_BITS-1:0] rsp_o
);
  localparam int unsigned CW = $clog2(LONG_LEN);
  localparam int unsigned TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] TX_LAST   = CW'(CMD_FRAME_LEN - 1);
  localparam logic [CW-1:0] TX_CRC_LO = CW'(CRC_SPAN_CMD);
  localparam logic [CW-1:0] S_LO      = CW'(0);
  localparam logic [CW-1:0] S_HI      = CW'(CRC_SPAN_CMD - 1);
  localparam logic [CW-1:0] L_LO      = CW'(LONG_LEN - RSP_BITS);
  localparam logic [CW-1:0] L_HI      = CW'(RSP_BITS - 1);
  localparam logic [CW-1:0] S_END     = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] L_END     = CW'(LONG_LEN - 1);
  localparam logic [TW-1:0] W_LAST    = TW'(TIMEOUT_CYC - 1);

  link_state_e            state_q;
  logic [CW-1:0]          cnt_q;
  logic [TW-1:0]          wcnt_q;
  logic [39:0]            tx_sr_q;
  logic [LONG_LEN-2:0]    rx_sr_q;
  logic                   need_q, long_q, mism_q;
  logic                   cmd_q, oe_q;

  logic [6:0]             crc;
  logic                   crc_clr, crc_upd, crc_shf, crc_bit;
  logic                   tx_bit, start_seen, last;
  logic                   in_content, in_crc;
  logic [CW-1:0]          c_lo, c_hi, c_end;
  logic [LONG_LEN-1:0]    rx_full;

  assign c_lo  = long_q ? L_LO  : S_LO;
  assign c_hi  = long_q ? L_HI  : S_HI;
  assign c_end = long_q ? L_END : S_END;

  always_comb begin
    if (cnt_q < TX_CRC_LO)    tx_bit = tx_sr_q[39];
    else if (cnt_q < TX_LAST) tx_bit = crc[6];
    else                      tx_bit = 1'b1;
  end

  assign in_content = (state_q == ST_RX) && (cnt_q >= c_lo) && (cnt_q <= c_hi);
  assign in_crc     = (state_q == ST_RX) && (cnt_q > c_hi) && (cnt_q < c_end);
  assign start_seen = (state_q == ST_WAIT) && need_q && !cmd_i;
  assign last       = (state_q == ST_RX) && (cnt_q == c_end);

  assign crc_clr = start_i || ((state_q == ST_TX) && (cnt_q == TX_LAST));
  assign crc_upd = ((state_q == ST_TX) && (cnt_q < TX_CRC_LO))
                 || (start_seen && !long_q) || in_content;
  assign crc_shf = ((state_q == ST_TX) && (cnt_q >= TX_CRC_LO) && (cnt_q < TX_LAST))
                 || in_crc;
  assign crc_bit = (state_q == ST_TX) ? tx_sr_q[39] : cmd_i;

  sdcmd_crc7 crc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .shf_i  (crc_shf),
    .bit_i  (crc_bit),
    .crc_o  (crc)
  );

  always_comb begin
    evt_o      = '0;
    evt_o.sent = (state_q == ST_WAIT) && !need_q;
    evt_o.tmo  = (state_q == ST_WAIT) && need_q && cmd_i && (wcnt_q == W_LAST);
    evt_o.ok   = last && !mism_q && cmd_i;
    evt_o.fail = last && (mism_q || !cmd_i);
  end

  assign rx_full    = {rx_sr_q, cmd_i};
  assign rsp_we_o   = last;
  assign rsp_long_o = long_q;
  assign rsp_o      = long_q ? rx_full[RSP_BITS-1:0] : {96'b0, rx_full[39:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      need_q  <= 1'b0;
      long_q  <= 1'b0;
      mism_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tx_sr_q <= {1'b0, 1'b1, idx_i, arg_i};
          need_q  <= need_i;
          long_q  <= long_i;
          cnt_q   <= '0;
          state_q <= ST_TX;
        end
        ST_TX: begin
          if (cnt_q < TX_CRC_LO) tx_sr_q <= {tx_sr_q[38:0], 1'b0};
          if (cnt_q == TX_LAST) begin
            cnt_q   <= '0;
            wcnt_q  <= '0;
            state_q <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!need_q) begin
            state_q <= ST_IDLE;
          end else if (!cmd_i) begin
            rx_sr_q <= rx_full[LONG_LEN-2:0];
            mism_q  <= 1'b0;
            cnt_q   <= CW'(1);
            state_q <= ST_RX;
          end else if (wcnt_q == W_LAST) begin
            state_q <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_RX: begin
          rx_sr_q <= rx_full[LONG_LEN-2:0];
          if (in_crc && (cmd_i != crc[6])) mism_q <= 1'b1;
          if (last) state_q <= ST_IDLE;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      cmd_q <= (state_q == ST_TX) ? tx_bit : 1'b1;
      oe_q  <= (state_q == ST_TX);
    end
  end

  assign cmd_o    = cmd_q;
  assign cmd_oe_o = oe_q;
  assign busy_o   = (state_q != ST_IDLE);

  p_one_outcome_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));
  p_line_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_o);
  p_start_only_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE));
  p_oe_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !cmd_oe_o ##1 cmd_oe_o);
endmodule

// File: rtl/sdcmd_regfile.sv
module sdcmd_regfile
  import sdcmd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [2:0]          raddr_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  evt_t                evt_i,
  input  logic                rsp_we_i,
  input  logic                rsp_long_i,
  input  logic [RSP_BITS-1:0] rsp_i,
  output logic                start_o,
  output logic [5:0]          start_idx_o,
  output logic                start_need_o,
  output logic                start_long_o,
  output logic [31:0]         arg_o
);
  localparam int unsigned NWORD = RSP_BITS / 32;

  logic [31:0] arg_q;
  logic [5:0]  idx_q;
  logic        need_q, long_q, app_q;
  logic [3:0]  stat_q;
  logic [3:0]  clr_mask;
  logic [31:0] rsp_q [NWORD];
  logic        wr_arg, wr_cmd;

  assign wr_arg   = wr_i && (addr_i == A_ARG) && !busy_i;
  assign wr_cmd   = wr_i && (addr_i == A_CMD) && !busy_i;
  assign clr_mask = (wr_i && (addr_i == A_CLR)) ? wdata_i[3:0] : 4'b0;

  assign start_o      = wr_cmd && wdata_i[F_EN];
  assign start_idx_o  = wdata_i[5:0];
  assign start_need_o = wdata_i[F_NEED];
  assign start_long_o = wdata_i[F_LONG];
  assign arg_o        = arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q  <= '0;
      idx_q  <= '0;
      need_q <= 1'b0;
      long_q <= 1'b0;
      app_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_arg) arg_q <= wdata_i;
      if (wr_cmd) begin
        idx_q  <= wdata_i[5:0];
        need_q <= wdata_i[F_NEED];
        long_q <= wdata_i[F_LONG];
        app_q  <= wdata_i[F_APP];
      end
      stat_q <= (stat_q & ~clr_mask) | evt_i;
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               rsp_q[w] <= '0;
      else if (rsp_we_i && (rsp_long_i || w == 0)) rsp_q[w] <= rsp_i[32*w +: 32];
    end
  end

  always_comb begin
    unique case (raddr_i)
      A_ARG:   rdata_o = arg_q;
      A_CMD:   rdata_o = {22'b0, busy_i, app_q, long_q, need_q, idx_q};
      A_STAT:  rdata_o = {28'b0, stat_q};
      A_CLR:   rdata_o = '0;
      default: rdata_o = rsp_q[raddr_i[1:0]];
    endcase
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  p_busy_arg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i && addr_i == A_ARG) |=> $stable(arg_q));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && addr_i == A_CLR) && (|stat_q)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [2:0]  reg_raddr_i,
  output logic [31:0] reg_rdata_o,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  input  logic        cmd_i
);
  logic                start, s_need, s_long, busy, rsp_we, rsp_long;
  logic [5:0]          s_idx;
  logic [31:0]         arg;
  logic [RSP_BITS-1:0] rsp;
  evt_t                evt;

  sdcmd_regfile regs_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .raddr_i      (reg_raddr_i),
    .rdata_o      (reg_rdata_o),
    .busy_i       (busy),
    .evt_i        (evt),
    .rsp_we_i     (rsp_we),
    .rsp_long_i   (rsp_long),
    .rsp_i        (rsp),
    .start_o      (start),
    .start_idx_o  (s_idx),
    .start_need_o (s_need),
    .start_long_o (s_long),
    .arg_o        (arg)
  );

  sdcmd_link #(.TIMEOUT_CYC(TIMEOUT_CYC)) link_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .idx_i      (s_idx),
    .arg_i      (arg),
    .need_i     (s_need),
    .long_i     (s_long),
    .cmd_i      (cmd_i),
    .cmd_o      (cmd_o),
    .cmd_oe_o   (cmd_oe_o),
    .busy_o     (busy),
    .evt_o      (evt),
    .rsp_we_o   (rsp_we),
    .rsp_long_o (rsp_long),
    .rsp_o      (rsp)
  );
endmodule

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic        cmd_o, cmd_oe, cmd_in = 1'b1;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  sdcmd_engine dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_addr_i  (waddr),
    .reg_wdata_i (wdata),
    .reg_raddr_i (raddr),
    .reg_rdata_o (rdata),
    .cmd_o       (cmd_o),
    .cmd_oe_o    (cmd_oe),
    .cmd_i       (cmd_in)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int top, input int n);
    logic [6:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = v[top-i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [31:0] cmd_word(input logic [5:0] idx, input bit need, input bit lng,
                                           input bit app, input bit en);
    return {22'b0, en, app, lng, need, idx};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  // returns at the negedge inside the end-bit cycle
  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit need,
                          input bit lng, input bit app, output logic [47:0] frame, output bit oe_ok);
    reg_write(3'd0, arg);
    reg_write(3'd1, cmd_word(idx, need, lng, app, 1'b1));
    oe_ok = (cmd_oe == 1'b0);
    frame = '0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      if (cmd_oe !== 1'b1) oe_ok = 1'b0;
      frame = {frame[46:0], cmd_o};
    end
  endtask

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] f;
    f = {1'b0, 1'b1, idx, arg, 7'h00, 1'b1};
    f[7:1] = crc7({88'b0, f}, 47, 40);
    return f;
  endfunction

  // from the end-bit cycle: wait d cycles after cycle 1 starts, then drive len bits
  task automatic respond(input logic [135:0] v, input int len, input int d, input logic [3:0] clr_at_end);
    @(negedge clk);
    repeat (d) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      cmd_in = v[len-1-i];
      if (i == len - 1 && clr_at_end != 4'b0) begin
        wr = 1'b1; waddr = 3'd3; wdata = {28'b0, clr_at_end};
      end
      @(negedge clk);
    end
    cmd_in = 1'b1;
    wr = 1'b0;
  endtask

  task automatic clear_all();
    reg_write(3'd3, 32'hF);
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] st);
    logic [47:0] r;
    r = {2'b00, idx, st, 7'h00, 1'b1};
    r[7:1] = crc7({88'b0, r}, 47, 40);
    return r;
  endfunction

  function automatic logic [135:0] long_rsp(input logic [119:0] body);
    logic [135:0] r;
    r = {8'h3F, body, 7'h00, 1'b1};
    r[7:1] = crc7(r, 127, 120);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0]  v, w0, w1, w2, w3;
    logic [47:0]  fr, rs;
    logic [135:0] lr;
    bit           oe_ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd2, v); chk(v == 0, "R1 status", v, 0);
    for (int a = 4; a < 8; a++) begin
      reg_read(3'(a), v); chk(v == 0, "R1 response word", v, 0);
    end
    reg_read(3'd1, v); chk(v[9] == 1'b0, "R1 idle", v[9], 0);
    chk(cmd_oe == 1'b0 && cmd_o == 1'b1, "R1 line", {cmd_oe, cmd_o}, 2'b01);

    // R2 R3 R8 sweep of all indices without response
    for (int i = 0; i < 64; i++) begin
      logic [31:0] arg;
      arg = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
      send_cmd(6'(i), arg, 1'b0, 1'b0, 1'b0, fr, oe_ok);
      chk(fr == exp_frame(6'(i), arg), "R2 frame", fr, exp_frame(6'(i), arg));
      chk(oe_ok, "R2 oe window", oe_ok, 1);
      reg_read(3'd2, v); chk(v == 0, "R3 no early sent", v, 0);
      @(negedge clk);
      chk(cmd_oe == 1'b0, "R2 oe released", cmd_oe, 0);
      reg_read(3'd2, v); chk(v == 32'h8, "R3 sent only", v, 32'h8);
      clear_all();
      reg_read(3'd2, v); chk(v == 0, "R8 cleared", v, 0);
    end

    // R10 enable clear: stores fields, starts nothing
    reg_write(3'd1, cmd_word(6'd17, 1'b1, 1'b0, 1'b1, 1'b0));
    oe_ok = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (cmd_oe !== 1'b0) oe_ok = 1'b0;
    end
    chk(oe_ok, "R10 no start without enable", oe_ok, 1);
    reg_read(3'd1, v); chk(v == cmd_word(6'd17, 1'b1, 1'b0, 1'b1, 1'b0), "R10 readback", v,
                           cmd_word(6'd17, 1'b1, 1'b0, 1'b1, 1'b0));
    reg_read(3'd2, v); chk(v == 0, "R10 no status", v, 0);

    // R10 app flag has no effect on frame
    send_cmd(6'd55, 32'hCAFE0001, 1'b0, 1'b0, 1'b1, fr, oe_ok);
    chk(fr == exp_frame(6'd55, 32'hCAFE0001), "R10 app frame", fr, exp_frame(6'd55, 32'hCAFE0001));
    @(negedge clk);
    reg_read(3'd1, v); chk(v[8] == 1'b1, "R10 app readback", v[8], 1);
    clear_all();

    // R5 R7 short response, good CRC
    send_cmd(6'd13, 32'h0000_1234, 1'b1, 1'b0, 1'b0, fr, oe_ok);
    reg_read(3'd1, v); chk(v[9] == 1'b1, "R9 busy", v[9], 1);
    rs = short_rsp(6'd13, 32'hA5C3_0F96);
    respond({88'b0, rs}, 48, 2, 4'b0);
    reg_read(3'd2, v); chk(v == 32'h1, "R5 R7 crc good only", v, 32'h1);
    reg_read(3'd4, v); chk(v == 32'hA5C3_0F96, "R5 word0", v, 32'hA5C3_0F96);
    reg_read(3'd5, v); chk(v == 0, "R5 word1 untouched", v, 0);
    reg_read(3'd1, v); chk(v[9] == 1'b0, "R9 idle after", v[9], 0);
    clear_all();

    // R5 R7 short response, bad CRC and bad end bit
    for (int t = 0; t < 2; t++) begin
      send_cmd(6'd7, 32'h1, 1'b1, 1'b0, 1'b0, fr, oe_ok);
      rs = short_rsp(6'd7, 32'h0BAD_0000 + 32'(t));
      if (t == 0) rs[3] = ~rs[3]; else rs[0] = 1'b0;
      respond({88'b0, rs}, 48, 0, 4'b0);
      reg_read(3'd2, v); chk(v == 32'h2, "R5 R7 crc error only", v, 32'h2);
      reg_read(3'd4, v); chk(v == 32'h0BAD_0000 + 32'(t), "R5 word0 on error", v, 32'h0BAD_0000 + 32'(t));
      clear_all();
    end

    // R6 long response good then bad
    for (int t = 0; t < 2; t++) begin
      logic [119:0] body;
      body = {32'h0123_4567, 32'h89AB_CDEF, 32'hDEAD_BEEF, 24'h55AA33} ^ {120{t[0]}};
      send_cmd(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, fr, oe_ok);
      lr = long_rsp(body);
      if (t == 1) lr[60] = ~lr[60];
      respond(lr, 136, 5, 4'b0);
      reg_read(3'd2, v);
      chk(v == (t == 0 ? 32'h1 : 32'h2), "R6 R7 long outcome", v, (t == 0 ? 32'h1 : 32'h2));
      reg_read(3'd7, w3); reg_read(3'd6, w2); reg_read(3'd5, w1); reg_read(3'd4, w0);
      chk({w3, w2, w1, w0} == lr[127:0], "R6 long words", {w3, w2, w1, w0}, lr[127:0]);
      clear_all();
    end

    // R4 timeout exact edge, no response
    send_cmd(6'd8, 32'h1AA, 1'b1, 1'b0, 1'b0, fr, oe_ok);
    repeat (63) @(negedge clk);
    reg_read(3'd2, v); chk(v == 0, "R4 no timeout before window end", v, 0);
    @(negedge clk);
    reg_read(3'd2, v); chk(v == 32'h4, "R4 R7 timeout only", v, 32'h4);
    clear_all();

    // R4 latest accepted start and first rejected start
    for (int d = 62; d < 64; d++) begin
      send_cmd(6'd9, 32'h0, 1'b1, 1'b0, 1'b0, fr, oe_ok);
      rs = short_rsp(6'd9, 32'h0000_0900 + 32'(d));
      respond({88'b0, rs}, 48, d, 4'b0);
      reg_read(3'd2, v);
      chk(v == (d == 62 ? 32'h1 : 32'h4), "R4 start window edge", v, (d == 62 ? 32'h1 : 32'h4));
      clear_all();
    end

    // R8 set wins over same-edge clear (sent), stale ok bit cleared in same write
    send_cmd(6'd11, 32'h0, 1'b1, 1'b0, 1'b0, fr, oe_ok);
    respond({88'b0, short_rsp(6'd11, 32'h77)}, 48, 0, 4'b0);
    send_cmd(6'd12, 32'h0, 1'b0, 1'b0, 1'b0, fr, oe_ok);
    wr = 1'b1; waddr = 3'd3; wdata = 32'h9;
    @(negedge clk);
    wr = 1'b0;
    reg_read(3'd2, v); chk(v == 32'h8, "R8 sent survives same-edge clear", v, 32'h8);
    clear_all();

    // R8 set wins for crc good
    send_cmd(6'd14, 32'h0, 1'b1, 1'b0, 1'b0, fr, oe_ok);
    respond({88'b0, short_rsp(6'd14, 32'h88)}, 48, 1, 4'b1);
    reg_read(3'd2, v); chk(v == 32'h1, "R8 ok survives same-edge clear", v, 32'h1);
    clear_all();

    // R9 writes ignored while busy
    send_cmd(6'd5, 32'hAAAA_5555, 1'b1, 1'b0, 1'b0, fr, oe_ok);
    reg_write(3'd0, 32'h1111_2222);
    reg_write(3'd1, cmd_word(6'd9, 1'b0, 1'b0, 1'b0, 1'b1));
    oe_ok = 1'b1;
    repeat (70) begin
      @(negedge clk);
      if (cmd_oe !== 1'b0) oe_ok = 1'b0;
    end
    chk(oe_ok, "R9 no second command", oe_ok, 1);
    reg_read(3'd0, v); chk(v == 32'hAAAA_5555, "R9 arg kept", v, 32'hAAAA_5555);
    reg_read(3'd1, v); chk(v[5:0] == 6'd5, "R9 cmd kept", v[5:0], 5);
    reg_read(3'd2, v); chk(v == 32'h4, "R9 R4 timeout", v, 32'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule